// File: doc/BRIEF.md
# Multi-Mode I/O Chip Select Decoder

This block sits behind a host-side bus decoder and turns I/O cycle addresses into two active-low chip selects for byte-wide peripherals on a secondary bus. While a chip select is active, it also drives the low address pins of that bus. Each chip select has its own programmable base address and a disable bit. A write-once lock freezes that base address and disable bit until the next hard reset, so that early boot code can fix the decode for good.

A single global mode field applies to both chip selects and sets how the address is split. In the wide mode, bits 11..2 are compared and bits 1..0 pass through. In the nibble mode, bits 11..4 are compared and bits 3..0 pass through. In the pair mode, bits 11..3 and bit 1 are compared, bit 0 must be low, and bit 2 passes through. The pair mode therefore serves register pairs at a base and base+4. Every decode also requires address bits 15..12 to be zero. Outputs are registered: the result for the cycle presented before a clock edge appears after that edge.

Top module: `cs_decoder`

## Requirements
- R1: A hard reset (rstN low) drives both chip selects high and the address pins to zero. It sets the mode to 2'b00, clears every base address and lock bit, and sets every disable bit.
- R2: A chip select can assert only when cycValid and cycIo are both 1 and cycAddr[15:12] is zero. In every other case both chip selects are high.
- R3: With mode 2'b00, a chip select asserts when cycAddr[11:2] equals its base bits 11..2. While it is active, xAddr = {2'b00, cycAddr[1:0]}.
- R4: With mode 2'b01, a chip select asserts when cycAddr[11:4] equals its base bits 11..4. Base bits 3..1 are ignored. While it is active, xAddr = cycAddr[3:0].
- R5: With mode 2'b10, a chip select asserts when cycAddr[11:3] and cycAddr[1] equal the corresponding base bits and cycAddr[0] is 0. While it is active, xAddr = {1'b0, cycAddr[2], 2'b00}.
- R6: Mode 2'b11 is reserved, and no chip select asserts while it is set.
- R7: When a chip select's disable bit is 1, that chip select stays high for every address.
- R8: Once a chip select's lock bit is set, writes to its low byte and high byte are ignored and the lock bit stays set. Only a hard reset clears it. The lock of one chip select does not affect the other.
- R9: If both chip selects match, only chip select 1 (csN[0]) asserts. At most one csN bit is low in any cycle.
- R10: Outputs are registered with one cycle of latency. When no chip select is active, xAddr is zero, so outputs go idle one cycle after cycValid drops.
- R11: The configuration write port (cfgWrEn, cfgSel, cfgWrData) decodes cfgSel as follows.
  - cfgSel 0 writes the mode field from data[1:0].
  - cfgSel 1 and 2 write the low byte and high byte of chip select 1. cfgSel 3 and 4 do the same for chip select 2.
  - A low-byte write stores data[7:1] as base bits 7..1 and data[0] as the disable bit.
  - A high-byte write stores data[3:0] as base bits 11..8 and data[7] as the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgWrData | input | 8 | Configuration write data |
| cycValid | input | 1 | A decoded bus cycle is present |
| cycIo | input | 1 | The present cycle is an I/O cycle |
| cycAddr | input | 16 | I/O cycle address |
| csN | output | 2 | Active-low chip selects; bit 0 is chip select 1 |
| xAddr | output | 4 | Secondary bus low address pins |

## Verification
The bench targets the following corner cases:
- Addresses one step outside each compare window. A design that compares too few bits asserts on these.
- In the pair mode, odd addresses and the base+4 partner. A design that ignores bit 0, or compares bit 2, fails one of these.
- In the nibble mode, bits left in the low base bits. A design that does not mask them would miss matches.
- Overlapping bases. Without the priority rule, both chip selects assert.
- After the lock is set, writes to both bytes are attempted. A design with a leaky lock changes the decode.
- A mid-run hard reset. A design whose lock survives reset cannot be reprogrammed.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;

  // Global address-split mode
  typedef enum logic [1:0] {
    MODE_WIDE   = 2'b00,
    MODE_NIBBLE = 2'b01,
    MODE_PAIR   = 2'b10,
    MODE_RSVD   = 2'b11
  } xmode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic qualify;  // cycle is a valid, in-range I/O cycle under a legal mode
    logic wide;
    logic nibble;
    logic pair;
  } dec_strobe_t;

endpackage

// File: rtl/cs_decoder_ctrl.sv
module cs_decoder_ctrl
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  parameter int CMP_HI = 11,
  localparam int SEL_W = $clog2(2*NUM_CS+1),
  localparam int HI_W  = CMP_HI - 7,
  localparam int UP_W  = ADDR_W - CMP_HI - 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [7:0]                    cfgWrData,
  input  logic                          cycValid,
  input  logic                          cycIo,
  input  logic [UP_W-1:0]               addrUpper,
  output dec_strobe_t                   strobe,
  output logic [NUM_CS-1:0][HI_W-1:0]   baseHi,
  output logic [NUM_CS-1:0][6:0]        baseLo,
  output logic [NUM_CS-1:0]             csDisable,
  output logic [NUM_CS-1:0]             lockQ,
  output logic [1:0]                    modeQ
);

  localparam logic [SEL_W-1:0] MODE_SEL = '0;

  // Global mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_WIDE;
    end else if (cfgWrEn && cfgSel == MODE_SEL) begin
      modeQ <= cfgWrData[1:0];
    end
  end

  // Per chip select base, disable and write-once lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi    <= '0;
      baseLo    <= '0;
      csDisable <= '1;
      lockQ     <= '0;
    end else if (cfgWrEn) begin
      for (int k = 0; k < NUM_CS; k++) begin
        if (!lockQ[k]) begin
          if (cfgSel == SEL_W'(2*k+1)) begin
            baseLo[k]    <= cfgWrData[7:1];
            csDisable[k] <= cfgWrData[0];
          end
          if (cfgSel == SEL_W'(2*k+2)) begin
            baseHi[k] <= cfgWrData[HI_W-1:0];
            lockQ[k]  <= cfgWrData[7];
          end
        end
      end
    end
  end

  // Cycle qualification and mode strobes
  always_comb begin
    strobe.qualify = cycValid && cycIo && (addrUpper == '0) && (modeQ != MODE_RSVD);
    strobe.wide    = (modeQ == MODE_WIDE);
    strobe.nibble  = (modeQ == MODE_NIBBLE);
    strobe.pair    = (modeQ == MODE_PAIR);
  end

endmodule

// File: rtl/cs_decoder_dp.sv
module cs_decoder_dp
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CMP_HI = 11,
  localparam int XA_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dec_strobe_t                   strobe,
  input  logic [CMP_HI:0]               addr,
  input  logic [NUM_CS-1:0][CMP_HI:1]   baseImg,
  input  logic [NUM_CS-1:0]             csDisable,
  output logic [NUM_CS-1:0]             csN,
  output logic [XA_W-1:0]               xAddr
);

  logic [NUM_CS-1:0] hit;
  logic [NUM_CS-1:0] grant;
  logic [XA_W-1:0]   xNext;
  logic              taken;

  // Per chip select compare
  always_comb begin
    for (int k = 0; k < NUM_CS; k++) begin
      hit[k] = strobe.qualify && !csDisable[k] && (
                 (strobe.wide   && addr[CMP_HI:2] == baseImg[k][CMP_HI:2]) ||
                 (strobe.nibble && addr[CMP_HI:4] == baseImg[k][CMP_HI:4]) ||
                 (strobe.pair   && addr[CMP_HI:3] == baseImg[k][CMP_HI:3] &&
                                   addr[1] == baseImg[k][1] && !addr[0]));
    end
  end

  // Fixed priority: lowest index wins
  always_comb begin
    taken = 1'b0;
    for (int k = 0; k < NUM_CS; k++) begin
      grant[k] = hit[k] && !taken;
      taken    = taken || hit[k];
    end
  end

  // Pass-through address pins
  always_comb begin
    xNext = '0;
    if (taken) begin
      if (strobe.wide)   xNext = {2'b00, addr[1:0]};
      if (strobe.nibble) xNext = addr[3:0];
      if (strobe.pair)   xNext = {1'b0, addr[2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN   <= '1;
      xAddr <= '0;
    end else begin
      csN   <= ~grant;
      xAddr <= xNext;
    end
  end

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_decoder_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  parameter int CMP_HI = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWrEn,
  input  logic [$clog2(2*NUM_CS+1)-1:0]  cfgSel,
  input  logic [7:0]                     cfgWrData,
  input  logic                           cycValid,
  input  logic                           cycIo,
  input  logic [ADDR_W-1:0]              cycAddr,
  output logic [NUM_CS-1:0]              csN,
  output logic [3:0]                     xAddr
);

  localparam int HI_W = CMP_HI - 7;

  dec_strobe_t                   strobe;
  logic [NUM_CS-1:0][HI_W-1:0]   baseHi;
  logic [NUM_CS-1:0][6:0]        baseLo;
  logic [NUM_CS-1:0][CMP_HI:1]   baseImg;
  logic [NUM_CS-1:0]             csDisable;
  logic [NUM_CS-1:0]             lockVec;
  logic [1:0]                    modeQ;

  cs_decoder_ctrl #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .CMP_HI (CMP_HI)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .cycValid  (cycValid),
    .cycIo     (cycIo),
    .addrUpper (cycAddr[ADDR_W-1:CMP_HI+1]),
    .strobe    (strobe),
    .baseHi    (baseHi),
    .baseLo    (baseLo),
    .csDisable (csDisable),
    .lockQ     (lockVec),
    .modeQ     (modeQ)
  );

  for (genvar k = 0; k < NUM_CS; k++) begin : g_img
    assign baseImg[k] = {baseHi[k], baseLo[k]};
  end

  cs_decoder_dp #(
    .NUM_CS (NUM_CS),
    .CMP_HI (CMP_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (cycAddr[CMP_HI:0]),
    .baseImg   (baseImg),
    .csDisable (csDisable),
    .csN       (csN),
    .xAddr     (xAddr)
  );

endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk #(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  parameter int CMP_HI = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycValid,
  input logic              cycIo,
  input logic [ADDR_W-1:0] cycAddr,
  input logic [NUM_CS-1:0] csN,
  input logic [3:0]        xAddr,
  input logic [1:0]        modeQ,
  input logic [NUM_CS-1:0] lockVec
);

  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_unqualified_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!(cycValid && cycIo) || cycAddr[ADDR_W-1:CMP_HI+1] != '0) |=> (&csN));

  assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b11) |=> (&csN));

  assert_pair_odd_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b10 && cycAddr[0]) |=> (&csN));

  assert_quiet_pins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> (xAddr == 4'h0));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((lockVec & $past(lockVec)) == $past(lockVec)));

endmodule

bind cs_decoder cs_decoder_chk #(
  .NUM_CS (NUM_CS),
  .ADDR_W (ADDR_W),
  .CMP_HI (CMP_HI)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cycValid (cycValid),
  .cycIo    (cycIo),
  .cycAddr  (cycAddr),
  .csN      (csN),
  .xAddr    (xAddr),
  .modeQ    (modeQ),
  .lockVec  (lockVec)
);

// File: tb/cs_decoder_tb.sv
`timescale 1ns/1ps
module cs_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [7:0]  cfgWrData = '0;
  logic        cycValid = 1'b0;
  logic        cycIo = 1'b0;
  logic [15:0] cycAddr = '0;
  logic [1:0]  csN;
  logic [3:0]  xAddr;

  always #2 clk = ~clk;  // 250 MHz

  cs_decoder u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cycValid(cycValid), .cycIo(cycIo),
    .cycAddr(cycAddr), .csN(csN), .xAddr(xAddr)
  );

  typedef struct {
    logic [1:0] cs;
    logic [3:0] xa;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench reference state
  logic [1:0]  mMode;
  logic [15:0] mBase [2];
  logic        mDis  [2];
  logic        mLock [2];

  task automatic modelReset();
    mMode = 2'b00;
    for (int k = 0; k < 2; k++) begin
      mBase[k] = '0; mDis[k] = 1'b1; mLock[k] = 1'b0;
    end
  endtask

  function automatic exp_t predict(logic [15:0] a, logic v, logic io, string tag);
    exp_t e;
    logic [1:0] hit;
    e.cs = 2'b11; e.xa = 4'h0; e.tag = tag;
    for (int k = 0; k < 2; k++) begin
      hit[k] = 1'b0;
      if (v && io && a[15:12] == 4'h0 && !mDis[k]) begin
        case (mMode)
          2'b00: hit[k] = (a[11:2] == mBase[k][11:2]);
          2'b01: hit[k] = (a[11:4] == mBase[k][11:4]);
          2'b10: hit[k] = (a[11:3] == mBase[k][11:3]) && (a[1] == mBase[k][1]) && !a[0];
          default: hit[k] = 1'b0;
        endcase
      end
    end
    if (hit[0]) e.cs = 2'b10;
    else if (hit[1]) e.cs = 2'b01;
    if (hit != 2'b00) begin
      case (mMode)
        2'b00: e.xa = {2'b00, a[1:0]};
        2'b01: e.xa = a[3:0];
        default: e.xa = {1'b0, a[2], 2'b00};
      endcase
    end
    return e;
  endfunction

  task automatic ioCycle(logic [15:0] a, logic v, logic io, string tag);
    @(negedge clk);
    cfgWrEn = 1'b0; cycValid = v; cycIo = io; cycAddr = a;
    q.push_back(predict(a, v, io, tag));
  endtask

  task automatic expectCs(logic [15:0] a, logic [1:0] cs, string tag);
    exp_t e;
    e = predict(a, 1'b1, 1'b1, tag);
    checks++;
    if (e.cs !== cs) begin
      errors++;
      $display("FAIL %s model sanity: got cs=%b expected cs=%b", tag, e.cs, cs);
    end
    ioCycle(a, 1'b1, 1'b1, tag);
  endtask

  task automatic cfgWrite(logic [2:0] sel, logic [7:0] d, string tag);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d; cycValid = 1'b0;
    q.push_back(predict(16'h0, 1'b0, 1'b0, tag));
    if (sel == 3'd0) mMode = d[1:0];
    for (int k = 0; k < 2; k++) begin
      if (!mLock[k] && sel == 3'(2*k+1)) begin
        mBase[k][7:1] = d[7:1]; mDis[k] = d[0];
      end
      if (!mLock[k] && sel == 3'(2*k+2)) begin
        mBase[k][11:8] = d[3:0]; mLock[k] = d[7];
      end
    end
  endtask

  task automatic hardReset();
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0; cycValid = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (csN !== e.cs || xAddr !== e.xa) begin
          errors++;
          $display("FAIL %s: got csN=%b xAddr=%h expected csN=%b xAddr=%h",
                   e.tag, csN, xAddr, e.cs, e.xa);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R10 watchdog: got hung run expected completion");
    summary();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (csN !== 2'b11 || xAddr !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset: got csN=%b xAddr=%h expected csN=11 xAddr=0", csN, xAddr);
    end
    // R1: disable bits set by reset, base 0 must not decode
    ioCycle(16'h0000, 1'b1, 1'b1, "R1 disabled after reset");

    // R11: program cs1 = 0x300, cs2 = 0x310, wide mode
    cfgWrite(3'd0, 8'h00, "R11 mode write");
    cfgWrite(3'd2, 8'h03, "R11 cs1 high");
    cfgWrite(3'd1, 8'h00, "R11 cs1 low");
    cfgWrite(3'd4, 8'h03, "R11 cs2 high");
    cfgWrite(3'd3, 8'h10, "R11 cs2 low");
    expectCs(16'h0302, 2'b10, "R3 wide cs1");
    expectCs(16'h0313, 2'b01, "R3 wide cs2");
    expectCs(16'h0304, 2'b11, "R3 wide outside window");
    expectCs(16'h0301, 2'b10, "R10 back to back");
    ioCycle(16'h0301, 1'b0, 1'b1, "R10 idle after valid drops");
    expectCs(16'h1302, 2'b11, "R2 upper bits nonzero");
    ioCycle(16'h0302, 1'b1, 1'b0, "R2 non-io cycle");

    // R9: overlapping bases
    cfgWrite(3'd3, 8'h00, "R9 cs2 overlaps cs1");
    expectCs(16'h0301, 2'b10, "R9 cs1 priority");

    // R4: nibble mode, cs1 low bits carry ignored ones
    cfgWrite(3'd3, 8'h10, "R4 cs2 restore");
    cfgWrite(3'd1, 8'h0C, "R4 cs1 low bits set");
    cfgWrite(3'd0, 8'h01, "R4 nibble mode");
    expectCs(16'h030F, 2'b10, "R4 nibble cs1");
    expectCs(16'h0301, 2'b10, "R4 low base bits ignored");
    expectCs(16'h031A, 2'b01, "R4 nibble cs2");
    expectCs(16'h0320, 2'b11, "R4 nibble outside");

    // R5: pair mode
    cfgWrite(3'd0, 8'h02, "R5 pair mode");
    cfgWrite(3'd2, 8'h00, "R5 cs1 high");
    cfgWrite(3'd1, 8'h60, "R5 cs1 low");
    cfgWrite(3'd4, 8'h00, "R5 cs2 high");
    cfgWrite(3'd3, 8'h62, "R5 cs2 low");
    expectCs(16'h0060, 2'b10, "R5 pair base");
    expectCs(16'h0064, 2'b10, "R5 pair plus4");
    expectCs(16'h0066, 2'b01, "R5 cs2 plus4");
    expectCs(16'h0062, 2'b01, "R5 cs2 base");
    expectCs(16'h0061, 2'b11, "R5 odd address");
    expectCs(16'h0068, 2'b11, "R5 pair outside");

    // R6: reserved mode
    cfgWrite(3'd0, 8'h03, "R6 reserved mode");
    expectCs(16'h0060, 2'b11, "R6 reserved no select");
    cfgWrite(3'd0, 8'h02, "R6 back to pair");

    // R7: disable
    cfgWrite(3'd1, 8'h61, "R7 disable cs1");
    expectCs(16'h0060, 2'b11, "R7 cs1 disabled");
    expectCs(16'h0062, 2'b01, "R7 cs2 unaffected");
    cfgWrite(3'd1, 8'h60, "R7 enable cs1");

    // R8: lock cs1
    cfgWrite(3'd2, 8'h80, "R8 set lock cs1");
    cfgWrite(3'd1, 8'h69, "R8 low write while locked");
    cfgWrite(3'd2, 8'h05, "R8 high write while locked");
    expectCs(16'h0060, 2'b10, "R8 locked base kept");
    expectCs(16'h0064, 2'b10, "R8 locked disable kept");
    cfgWrite(3'd3, 8'h63, "R8 cs2 still writable");
    expectCs(16'h0062, 2'b11, "R8 cs2 write took effect");

    // R8/R1: hard reset clears lock
    hardReset();
    @(negedge clk);
    checks++;
    if (csN !== 2'b11 || xAddr !== 4'h0) begin
      errors++;
      $display("FAIL R1 second reset: got csN=%b xAddr=%h expected csN=11 xAddr=0", csN, xAddr);
    end
    cfgWrite(3'd0, 8'h02, "R8 mode after reset");
    cfgWrite(3'd1, 8'h70, "R8 cs1 rewritable after reset");
    expectCs(16'h0070, 2'b10, "R8 new base after reset");
    expectCs(16'h0060, 2'b11, "R8 old base gone");
    ioCycle(16'h0, 1'b0, 1'b0, "R10 final idle");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule